// File: doc/BRIEF.md
# USB Host Test-Mode Controller

This block holds the electrical test selector for a two-port USB host and decides, port by port, whether test signalling is driven. One 4-bit selector serves both ports. A port drives the test only when its pull-down bit and its activate bit are both set, the module is enabled, and the host role is chosen. The selected code also decides whether start-of-frame packets may be sent on an active port, and whether a high-speed disconnect on that port is acted on or masked.

Software uses a small register bus. It sets the control bits, writes the selector while every pipe answers NAK and no port is active, and then activates the port under test. The selector guard rejects writes made out of order. A rejected write changes nothing and raises a sticky error bit. Once a test has been driven, the block records that fact. Normal operation is then withheld until the power-on reset input is pulsed.

The waveform generator, the transceiver and the protocol engine are outside this block. They consume its enable outputs.

Top module: `usbh_testmode_ctrl`

## Requirements
- R1: After power-on reset, the selector reads 0000, the error, latched and rearm bits are 0, the control register reads 0, every per-port output is 0 and normal_op is 1.
- R2: A selector write is accepted only if all of these hold: module-enable=1, host-select=1, at least one pull-down bit is 1, both activate bits are 0, every pipe_nak bit is 1, and the rearm bit is 0. The selector is read at TEST (address 1), bits [3:0].
- R3: A rejected selector write leaves the selector unchanged and sets the error bit (TEST bit 4). The error bit stays at 1 until power-on reset.
- R4: An accepted selector write sets hs_term on both ports. hs_term then stays set until power-on reset.
- R5: test_drive[p] is 1 exactly when the selector is nonzero, module-enable=1, host-select=1, pull-down[p]=1 and activate[p]=1.
- R6: sof_permit[p] is 1 when module-enable, host-select and activate[p] are all 1, unless the selector is 1011, in which case it is 0.
- R7: With selector 1101 and test_drive[p]=1, disc_mask[p] is 1 and disc_evt[p] is 0. Otherwise disc_evt[p] follows hs_disc_det[p] on an active port.
- R8: The latched bit (TEST bit 5) sets one cycle after any test_drive bit is 1. From then until power-on reset, normal_op is 0.
- R9: While the latched bit is 1, a selector write of 0000 is rejected.
- R10: Any driven test sets the rearm bit (TEST bit 6), which blocks selector writes. The rearm bit clears only on a CTRL write that makes module-enable 0 and both activate bits 0.
- R11: CTRL (address 0) holds module-enable in bit 0, host-select in bit 1, pull-down[1:0] in bits [3:2] and activate[1:0] in bits [5:4]. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 CTRL, 1 TEST) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| pipe_nak | input | NUM_PIPES | 1 per pipe whose response is NAK |
| hs_disc_det | input | 2 | High-speed disconnect detected, per port |
| test_drive | output | 2 | Test signalling enable, per port |
| hs_term | output | 2 | High-speed termination request, per port |
| sof_permit | output | 2 | Start-of-frame emission allowed, per port |
| disc_mask | output | 2 | Disconnect handling masked, per port |
| disc_evt | output | 2 | Disconnect event to act on, per port |
| normal_op | output | 1 | Normal operation allowed (no test has run) |

## Verification
The hardest state to reach is the modify sequence after a test has run. The stimulus must activate a port to set the rearm bit, then clear only the activate bit so that the next write is still refused. Only after that does it write CTRL with enable and both activate bits cleared, re-enable, and load a new code. Along the way, the bench writes 0000 while the latched bit is set, to show that a register write cannot end test mode. It then walks the SE0-NAK and force-enable codes with mixed pull-down and activate settings across both ports, so that each output is seen to separate per port.

// File: rtl/usbh_tm_pkg.sv
package usbh_tm_pkg;
  localparam int TM_NPORT = 2;
  localparam int TM_SEL_W = 4;
  localparam int TM_CTRL_W = 6;

  localparam int TM_ADDR_CTRL = 0;
  localparam int TM_ADDR_TEST = 1;

  localparam logic [TM_SEL_W-1:0] TM_OFF      = 4'b0000;
  localparam logic [TM_SEL_W-1:0] TM_SE0_NAK  = 4'b1011;
  localparam logic [TM_SEL_W-1:0] TM_FORCE_EN = 4'b1101;

  typedef struct packed {
    logic [TM_NPORT-1:0] act;
    logic [TM_NPORT-1:0] pd;
    logic                host;
    logic                mod_en;
  } tm_ctrl_t;
endpackage

// File: rtl/usbh_tm_ctrl_reg.sv
module usbh_tm_ctrl_reg
  import usbh_tm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [TM_CTRL_W-1:0] wdata,
  output tm_ctrl_t             ctrl_q,
  output logic                 rearm_clr
);
  tm_ctrl_t ctrl_d;
  logic     ctrl_we;

  always_comb begin
    ctrl_we   = wr && (addr == ADDR_W'(TM_ADDR_CTRL));
    ctrl_d    = ctrl_q;
    if (ctrl_we) ctrl_d = tm_ctrl_t'(wdata);
    // A rearm needs enable and both activate bits dropped in one write
    rearm_clr = ctrl_we && !ctrl_d.mod_en && (ctrl_d.act == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/usbh_tm_sel_guard.sv
module usbh_tm_sel_guard
  import usbh_tm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int NUM_PIPES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [TM_SEL_W-1:0]  wsel,
  input  tm_ctrl_t             ctrl,
  input  logic [NUM_PIPES-1:0] pipe_nak,
  input  logic                 any_drive,
  input  logic                 rearm_clr,
  output logic [TM_SEL_W-1:0]  sel_q,
  output logic                 err_q,
  output logic                 lat_q,
  output logic                 rearm_q,
  output logic [TM_NPORT-1:0]  term_q
);
  logic                sel_we, accept;
  logic [TM_SEL_W-1:0] sel_d;
  logic                err_d, lat_d, rearm_d;
  logic [TM_NPORT-1:0] term_d;

  always_comb begin
    sel_we  = wr && (addr == ADDR_W'(TM_ADDR_TEST));
    accept  = sel_we && ctrl.mod_en && ctrl.host && (|ctrl.pd) &&
              (ctrl.act == '0) && (&pipe_nak) && !rearm_q &&
              !(lat_q && (wsel == TM_OFF));
    sel_d   = accept ? wsel : sel_q;
    term_d  = accept ? '1 : term_q;
    err_d   = err_q | (sel_we & ~accept);
    lat_d   = lat_q | any_drive;
    rearm_d = rearm_clr ? 1'b0 : (rearm_q | any_drive);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= TM_OFF;
      term_q  <= '0;
      err_q   <= 1'b0;
      lat_q   <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (accept) begin
        sel_q  <= sel_d;
        term_q <= term_d;
      end
      if (sel_we)    err_q <= err_d;
      if (any_drive) lat_q <= lat_d;
      if (any_drive || rearm_clr) rearm_q <= rearm_d;
    end
  end
endmodule

// File: rtl/usbh_tm_port.sv
module usbh_tm_port
  import usbh_tm_pkg::*;
(
  input  logic [TM_SEL_W-1:0] sel,
  input  logic                mod_en,
  input  logic                host,
  input  logic                pd,
  input  logic                act,
  input  logic                disc_det,
  output logic                drive,
  output logic                sof_ok,
  output logic                mask,
  output logic                evt
);
  logic live;

  always_comb begin
    live   = mod_en && host && act;
    drive  = live && pd && (sel != TM_OFF);
    sof_ok = live && (sel != TM_SE0_NAK);
    mask   = drive && (sel == TM_FORCE_EN);
    evt    = live && disc_det && !mask;
  end
endmodule

// File: rtl/usbh_testmode_ctrl.sv
module usbh_testmode_ctrl
  import usbh_tm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int NUM_PIPES = 8
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_PIPES-1:0] pipe_nak,
  input  logic [1:0]           hs_disc_det,
  output logic [1:0]           test_drive,
  output logic [1:0]           hs_term,
  output logic [1:0]           sof_permit,
  output logic [1:0]           disc_mask,
  output logic [1:0]           disc_evt,
  output logic                 normal_op
);
  localparam int TEST_RD_W = TM_SEL_W + 3;

  logic [1:0]          rst_sync_q;
  logic                rst_n_s;
  tm_ctrl_t            ctrl_q;
  logic                rearm_clr;
  logic [TM_SEL_W-1:0] sel_q;
  logic                err_q, lat_q, rearm_q;
  logic                wdata_unused;

  assign wdata_unused = ^reg_wdata[DATA_W-1:TM_CTRL_W];

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  usbh_tm_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[TM_CTRL_W-1:0]), .ctrl_q(ctrl_q), .rearm_clr(rearm_clr)
  );

  usbh_tm_sel_guard #(.ADDR_W(ADDR_W), .NUM_PIPES(NUM_PIPES)) u_guard (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .addr(reg_addr),
    .wsel(reg_wdata[TM_SEL_W-1:0]), .ctrl(ctrl_q), .pipe_nak(pipe_nak),
    .any_drive(|test_drive), .rearm_clr(rearm_clr),
    .sel_q(sel_q), .err_q(err_q), .lat_q(lat_q), .rearm_q(rearm_q),
    .term_q(hs_term)
  );

  for (genvar p = 0; p < TM_NPORT; p++) begin : g_port
    usbh_tm_port u_port (
      .sel(sel_q), .mod_en(ctrl_q.mod_en), .host(ctrl_q.host),
      .pd(ctrl_q.pd[p]), .act(ctrl_q.act[p]), .disc_det(hs_disc_det[p]),
      .drive(test_drive[p]), .sof_ok(sof_permit[p]),
      .mask(disc_mask[p]), .evt(disc_evt[p])
    );
  end

  assign normal_op = ~lat_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(TM_ADDR_CTRL))
      reg_rdata = DATA_W'(ctrl_q);
    else if (reg_addr == ADDR_W'(TM_ADDR_TEST))
      reg_rdata = DATA_W'({rearm_q, lat_q, err_q, sel_q});
  end

  initial begin
    if (DATA_W < TEST_RD_W) $error("DATA_W too narrow for TEST register");
  end
endmodule

// File: rtl/usbh_testmode_ctrl_chk.sv
module usbh_testmode_ctrl_chk
  import usbh_tm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [1:0]          test_drive,
  input logic [1:0]          sof_permit,
  input logic [1:0]          disc_mask,
  input logic [1:0]          hs_term,
  input logic                normal_op,
  input logic [TM_SEL_W-1:0] sel_q,
  input logic                err_q,
  input logic                lat_q,
  input tm_ctrl_t            ctrl_q
);
  assert_drive_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|test_drive) |-> ((test_drive & ~(ctrl_q.act & ctrl_q.pd)) == 2'b00) && (sel_q != TM_OFF));

  assert_no_sof_se0nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == TM_SE0_NAK) |-> (sof_permit == 2'b00));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |=> (lat_q && !normal_op));

  assert_term_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_term == 2'b11) |=> (hs_term == 2'b11));

  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADDR_W'(TM_ADDR_TEST)) && (ctrl_q.act != '0)) |=> $stable(sel_q));

  assert_mask_only_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|disc_mask) |-> (sel_q == TM_FORCE_EN));
endmodule

bind usbh_testmode_ctrl usbh_testmode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .test_drive(test_drive), .sof_permit(sof_permit), .disc_mask(disc_mask),
  .hs_term(hs_term), .normal_op(normal_op), .sel_q(sel_q), .err_q(err_q),
  .lat_q(lat_q), .ctrl_q(ctrl_q)
);

// File: tb/usbh_testmode_ctrl_bench.sv
module usbh_testmode_ctrl_bench;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NUM_PIPES = 8;

  logic                 clk = 1'b0;
  logic                 por_n = 1'b0;
  logic                 reg_wr = 1'b0;
  logic [ADDR_W-1:0]    reg_addr = '0;
  logic [DATA_W-1:0]    reg_wdata = '0;
  logic [DATA_W-1:0]    reg_rdata;
  logic [NUM_PIPES-1:0] pipe_nak = '1;
  logic [1:0]           hs_disc_det = 2'b00;
  logic [1:0]           test_drive, hs_term, sof_permit, disc_mask, disc_evt;
  logic                 normal_op;

  always #10 clk = ~clk;

  usbh_testmode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PIPES(NUM_PIPES)) u_usbh_testmode_ctrl (
    .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pipe_nak(pipe_nak),
    .hs_disc_det(hs_disc_det), .test_drive(test_drive), .hs_term(hs_term),
    .sof_permit(sof_permit), .disc_mask(disc_mask), .disc_evt(disc_evt),
    .normal_op(normal_op)
  );

  typedef enum int {K_RD, K_DRV, K_SOF, K_MASK, K_EVT, K_NORM, K_TERM} kind_e;
  typedef struct {
    string       req;
    kind_e       kind;
    logic [15:0] exp;
  } item_t;

  item_t sbq[$];
  event  sb_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic logic [15:0] observe(kind_e k);
    case (k)
      K_RD:    return 16'(reg_rdata);
      K_DRV:   return 16'(test_drive);
      K_SOF:   return 16'(sof_permit);
      K_MASK:  return 16'(disc_mask);
      K_EVT:   return 16'(disc_evt);
      K_NORM:  return 16'(normal_op);
      default: return 16'(hs_term);
    endcase
  endfunction

  // Monitor: pops expected items and compares with the design outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sbq.size() > 0) begin
        item_t       it;
        logic [15:0] got;
        it  = sbq.pop_front();
        got = observe(it.kind);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s (%s): actual 0x%0h expected 0x%0h", it.req, it.kind.name(), got, it.exp);
        end
      end
    end
  end

  task automatic expect_out(string req, kind_e k, logic [15:0] e);
    sbq.push_back('{req, k, e});
    ->sb_ev;
    #1;
  endtask

  task automatic expect_rd(string req, int a, logic [15:0] e);
    reg_addr = ADDR_W'(a);
    #1;
    expect_out(req, K_RD, e);
  endtask

  task automatic write_reg(int a, int d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = ADDR_W'(a);
    reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    expect_rd("R1 test reg", 1, 16'h00);
    expect_rd("R1 ctrl reg", 0, 16'h00);
    expect_out("R1 drive", K_DRV, 16'h0);
    expect_out("R1 sof", K_SOF, 16'h0);
    expect_out("R1 mask", K_MASK, 16'h0);
    expect_out("R1 normal", K_NORM, 16'h1);
    expect_out("R1 term", K_TERM, 16'h0);

    // R2: pipe not NAK blocks the write; R11 ctrl readback
    write_reg(0, 8'h07);
    expect_rd("R11 ctrl readback", 0, 16'h07);
    pipe_nak = 8'hF7;
    write_reg(1, 8'h04);
    expect_rd("R2 pipe not NAK rejects", 1, 16'h10);
    expect_out("R4 no term on reject", K_TERM, 16'h0);
    pipe_nak = '1;

    // R3: error clears only on reset
    do_reset();
    expect_rd("R3 err cleared by reset", 1, 16'h00);

    // R2: host-select cleared rejects
    write_reg(0, 8'h05);
    write_reg(1, 8'h03);
    expect_rd("R2 no host select rejects", 1, 16'h10);
    do_reset();

    // Main flow
    write_reg(0, 8'h07);
    write_reg(1, 8'h04);
    expect_rd("R2 accepted write", 1, 16'h04);
    expect_out("R4 term both ports", K_TERM, 16'h3);
    expect_out("R5 no drive without activate", K_DRV, 16'h0);
    expect_out("R8 normal before drive", K_NORM, 16'h1);

    hs_disc_det = 2'b11;
    write_reg(0, 8'h17);
    expect_out("R5 drive port0", K_DRV, 16'h1);
    expect_out("R6 sof port0", K_SOF, 16'h1);
    expect_out("R7 no mask for other code", K_MASK, 16'h0);
    expect_out("R7 disconnect passes", K_EVT, 16'h1);
    @(negedge clk);
    expect_out("R8 normal low after drive", K_NORM, 16'h0);
    expect_rd("R8 R10 latched and rearm", 1, 16'h64);

    write_reg(1, 8'h00);
    expect_rd("R3 write while active rejected", 1, 16'h74);
    expect_out("R3 drive unchanged", K_DRV, 16'h1);

    write_reg(0, 8'h07);
    write_reg(1, 8'h0B);
    expect_rd("R10 rearm still blocks", 1, 16'h74);

    write_reg(0, 8'h06);
    expect_rd("R10 rearm cleared", 1, 16'h34);
    write_reg(0, 8'h07);
    write_reg(1, 8'h00);
    expect_rd("R9 zero write rejected when latched", 1, 16'h34);
    write_reg(1, 8'h0B);
    expect_rd("R2 new code accepted", 1, 16'h3B);

    write_reg(0, 8'h3F);
    expect_out("R5 drive both", K_DRV, 16'h3);
    expect_out("R6 sof blocked by 1011", K_SOF, 16'h0);
    expect_out("R7 no mask for 1011", K_MASK, 16'h0);
    expect_out("R7 disconnect both", K_EVT, 16'h3);
    @(negedge clk);
    expect_rd("R10 rearm set again", 1, 16'h7B);

    write_reg(0, 8'h0E);
    expect_rd("R10 rearm cleared again", 1, 16'h3B);
    write_reg(0, 8'h0F);
    write_reg(1, 8'h0D);
    expect_rd("R2 force code accepted", 1, 16'h3D);

    write_reg(0, 8'h1F);
    expect_out("R5 force drive port0", K_DRV, 16'h1);
    expect_out("R6 force sof port0", K_SOF, 16'h1);
    expect_out("R7 force mask port0", K_MASK, 16'h1);
    expect_out("R7 force evt blocked", K_EVT, 16'h0);
    write_reg(0, 8'h3F);
    expect_out("R7 force mask both", K_MASK, 16'h3);
    expect_out("R6 force sof both", K_SOF, 16'h3);
    expect_out("R7 force evt none", K_EVT, 16'h0);
    write_reg(0, 8'h3B);
    expect_out("R5 pull-down gates port0", K_DRV, 16'h2);
    expect_out("R6 sof ignores pull-down", K_SOF, 16'h3);
    expect_out("R7 mask port1 only", K_MASK, 16'h2);
    expect_out("R7 evt port0 only", K_EVT, 16'h1);
    write_reg(0, 8'h3D);
    expect_out("R5 no host no drive", K_DRV, 16'h0);
    expect_out("R6 no host no sof", K_SOF, 16'h0);
    expect_out("R8 still latched", K_NORM, 16'h0);

    do_reset();
    expect_out("R8 normal after reset", K_NORM, 16'h1);
    expect_out("R4 term cleared by reset", K_TERM, 16'h0);
    expect_rd("R1 test reg after reset", 1, 16'h00);

    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule